// File: doc/BRIEF.md
# Two-Level Egress Frame Scheduler with Age Merge

This block picks the next frame descriptor for a single egress port that carries four traffic classes. Every class owns two descriptor queues, one for unicast and one for multicast frames. Upstream logic writes a descriptor each cycle at most, tagged with its class, its queue type and a 16-bit arrival stamp taken from a free-running counter. The transmitter pulls descriptors through a valid/ready handshake.

Selection works at two levels. Across classes the choice is strict: class 3 is the most urgent and class 0 the least, and the highest class that holds any descriptor wins. Inside that class, the unicast and multicast queues behave as one merged queue: the head with the older stamp goes first, where age is taken modulo 2^16 so that counter wrap causes no reordering. On a tie, unicast wins.

A two-state controller governs the offer. In state SCAN the grant follows the live arbitration result. If the offer is not taken in that cycle (transition SCAN->HOLD), the chosen queue is locked and the offer stays frozen in state HOLD until the transmitter accepts it (transition HOLD->SCAN). SCAN->SCAN occurs when nothing is offered or the offer is taken at once, and HOLD->HOLD while ready stays low. A descriptor leaves its queue only in the cycle the handshake completes.

Top module: `prio_age_sched`

## Requirements
- R1: While in state SCAN with grant_valid high, grant_class is the highest class (3 most urgent, 0 least) that has a descriptor in either of its queues.
- R2: Within the granted class, when both queues hold descriptors, the head whose stamp is older is granted; grant_mcast is 1 for the multicast queue and 0 for the unicast queue.
- R3: Stamp age is compared modulo 2^16: stamp a is older than stamp b when (b - a) taken as a 16-bit signed value is positive, so a head stamped 16'hFFF0 is older than one stamped 16'h0005.
- R4: When the unicast and multicast heads of the granted class carry equal stamps, the unicast head is granted.
- R5: When grant_valid is high and grant_ready is low, the next cycle offers the same class, queue type, stamp and data, even if a more urgent descriptor arrives; a descriptor is removed only in a cycle where grant_valid and grant_ready are both high.
- R6: Each queue holds 16 descriptors; queue_full bit (2*class + mcast) is high when that queue holds 16, and a push to a full queue is discarded, even in a cycle where that queue is also being popped.
- R7: When all eight queues are empty, grant_valid is low.
- R8: Descriptors of one queue are granted in the order they were pushed, with their stamp and data unchanged.
- R9: After reset all queues are empty, queue_full is all zero and grant_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Write a descriptor this cycle |
| push_class | input | 2 | Class of the pushed descriptor, 3 most urgent |
| push_mcast | input | 1 | 1 = multicast queue, 0 = unicast queue |
| push_stamp | input | 16 | Arrival stamp of the pushed descriptor |
| push_data | input | 16 | Descriptor payload |
| queue_full | output | 8 | Full flag per queue, bit index 2*class + mcast |
| grant_valid | output | 1 | A descriptor is on offer |
| grant_ready | input | 1 | Transmitter accepts the offer |
| grant_class | output | 2 | Class of the offered descriptor |
| grant_mcast | output | 1 | Queue type of the offered descriptor |
| grant_stamp | output | 16 | Stamp of the offered descriptor |
| grant_data | output | 16 | Payload of the offered descriptor |

## Verification
The age checks assume that any two heads compared are less than half the stamp range apart and that stamps within one queue never move backwards by more than that window; the stimulus draws every stamp from a counter that advances once per cycle, runs only a few thousand cycles and occasionally repeats the previous stamp to force ties. The counter starts just below its wrap point so that merged comparisons straddle the wrap early. Ready is driven low at random, and a directed phase holds it low while pushing one queue past capacity, so the frozen-offer and discarded-push paths are both reached.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [0:0] {
        ST_SCAN = 1'b0,
        ST_HOLD = 1'b1
    } sched_state_e;

endpackage

// File: rtl/desc_fifo.sv
module desc_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CNTW-1:0]  count;
    logic             do_wr, do_rd;

    assign empty   = (count == '0);
    assign full    = (count == CNTW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_rd) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // R6: occupancy never exceeds the depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNTW'(DEPTH));

    // R6: a write into a full queue leaves occupancy unchanged when nothing is read
    p_full_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (count == $past(count)));

endmodule

// File: rtl/age_pick.sv
module age_pick #(
    parameter int STAMP_W = 16
) (
    input  logic               u_valid,
    input  logic               m_valid,
    input  logic [STAMP_W-1:0] u_stamp,
    input  logic [STAMP_W-1:0] m_stamp,
    output logic               busy,
    output logic               pick_m
);
    logic [STAMP_W-1:0] gap;

    // positive (u - m) in signed modular terms means the multicast head is older
    assign gap  = u_stamp - m_stamp;
    assign busy = u_valid || m_valid;

    always_comb begin
        if (!m_valid) begin
            pick_m = 1'b0;
        end else if (!u_valid) begin
            pick_m = 1'b1;
        end else begin
            pick_m = !gap[STAMP_W-1] && (gap != '0);
        end
    end

endmodule

// File: rtl/prio_age_sched.sv
module prio_age_sched
    import sched_pkg::*;
#(
    parameter int NUM_CLASS = 4,
    parameter int DEPTH     = 16,
    parameter int STAMP_W   = 16,
    parameter int DATA_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_valid,
    input  logic [$clog2(NUM_CLASS)-1:0] push_class,
    input  logic                         push_mcast,
    input  logic [STAMP_W-1:0]           push_stamp,
    input  logic [DATA_W-1:0]            push_data,
    output logic [2*NUM_CLASS-1:0]       queue_full,
    output logic                         grant_valid,
    input  logic                         grant_ready,
    output logic [$clog2(NUM_CLASS)-1:0] grant_class,
    output logic                         grant_mcast,
    output logic [STAMP_W-1:0]           grant_stamp,
    output logic [DATA_W-1:0]            grant_data
);
    localparam int NQ = 2 * NUM_CLASS;
    localparam int CW = $clog2(NUM_CLASS);
    localparam int QW = CW + 1;
    localparam int EW = STAMP_W + DATA_W;

    logic [NQ-1:0]        q_empty, q_wr, q_rd;
    logic [EW-1:0]        q_head [NQ];
    logic [NUM_CLASS-1:0] cls_busy, cls_pick_m;

    sched_state_e state_q, state_d;
    logic [QW-1:0] lock_q, lock_d, live_idx, eff_idx;
    logic          live_any, fire;

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        for (genvar m = 0; m < 2; m++) begin : g_queue
            localparam int Q = 2 * c + m;
            assign q_wr[Q] = push_valid && (push_class == CW'(c)) && (push_mcast == 1'(m));
            assign q_rd[Q] = fire && (eff_idx == QW'(Q));
            desc_fifo #(
                .WIDTH (EW),
                .DEPTH (DEPTH)
            ) u_fifo (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (q_wr[Q]),
                .wr_data ({push_stamp, push_data}),
                .rd_en   (q_rd[Q]),
                .rd_data (q_head[Q]),
                .empty   (q_empty[Q]),
                .full    (queue_full[Q])
            );
        end
        age_pick #(
            .STAMP_W (STAMP_W)
        ) u_pick (
            .u_valid (!q_empty[2*c]),
            .m_valid (!q_empty[2*c+1]),
            .u_stamp (q_head[2*c][EW-1 -: STAMP_W]),
            .m_stamp (q_head[2*c+1][EW-1 -: STAMP_W]),
            .busy    (cls_busy[c]),
            .pick_m  (cls_pick_m[c])
        );
    end

    // strict priority: scanning upward lets the highest busy class win
    always_comb begin
        live_any = 1'b0;
        live_idx = '0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (cls_busy[c]) begin
                live_any = 1'b1;
                live_idx = {CW'(c), cls_pick_m[c]};
            end
        end
    end

    assign fire = grant_valid && grant_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            lock_q  <= '0;
        end else begin
            state_q <= state_d;
            lock_q  <= lock_d;
        end
    end

    always_comb begin
        state_d = state_q;
        lock_d  = lock_q;
        unique case (state_q)
            ST_SCAN: begin
                lock_d = live_idx;
                if (live_any && !grant_ready) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (grant_ready) begin
                    state_d = ST_SCAN;
                end
            end
            default: state_d = ST_SCAN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_HOLD: begin
                eff_idx     = lock_q;
                grant_valid = 1'b1;
            end
            default: begin
                eff_idx     = live_idx;
                grant_valid = live_any;
            end
        endcase
    end

    assign grant_class = eff_idx[QW-1:1];
    assign grant_mcast = eff_idx[0];
    assign grant_stamp = q_head[eff_idx][EW-1 -: STAMP_W];
    assign grant_data  = q_head[eff_idx][DATA_W-1:0];

    // R1: no busy class above the granted one
    p_strict_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && grant_valid) |->
            ((cls_busy >> grant_class) == NUM_CLASS'(1)));

    // R4: tied stamps in the granted class favour unicast
    p_equal_unicast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && grant_valid
         && !q_empty[{grant_class, 1'b0}] && !q_empty[{grant_class, 1'b1}]
         && q_head[{grant_class, 1'b0}][EW-1 -: STAMP_W] == q_head[{grant_class, 1'b1}][EW-1 -: STAMP_W])
        |-> !grant_mcast);

    // R5: an offer not taken stays frozen on the next cycle
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_ready) |=>
            (grant_valid && $stable(grant_class) && $stable(grant_mcast)
             && $stable(grant_stamp) && $stable(grant_data)));

    // R7: nothing offered with every queue empty
    p_no_valid_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&q_empty) |-> !grant_valid);

endmodule

// File: tb/prio_age_sched_tb.sv
module prio_age_sched_tb_top;

    typedef struct packed {
        logic [15:0] st;
        logic [15:0] dat;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_valid, push_mcast, grant_ready;
    logic [1:0]  push_class;
    logic [15:0] push_stamp, push_data;
    logic [7:0]  queue_full;
    logic        grant_valid, grant_mcast;
    logic [1:0]  grant_class;
    logic [15:0] grant_stamp, grant_data;

    always #5 clk = ~clk;

    prio_age_sched dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_valid  (push_valid),
        .push_class  (push_class),
        .push_mcast  (push_mcast),
        .push_stamp  (push_stamp),
        .push_data   (push_data),
        .queue_full  (queue_full),
        .grant_valid (grant_valid),
        .grant_ready (grant_ready),
        .grant_class (grant_class),
        .grant_mcast (grant_mcast),
        .grant_stamp (grant_stamp),
        .grant_data  (grant_data)
    );

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    ent_t        mq [8][$];
    bit          hold;
    int          lock_idx;
    logic [15:0] ctr, last_st, tag;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // age measured back from the current counter; larger age = earlier arrival
    function automatic int pick_idx();
        for (int c = 3; c >= 0; c--) begin
            int nu = mq[2*c].size();
            int nm = mq[2*c+1].size();
            if (nu != 0 || nm != 0) begin
                if (nm == 0) return 2*c;
                if (nu == 0) return 2*c + 1;
                begin
                    logic [15:0] au = ctr - mq[2*c][0].st;
                    logic [15:0] am = ctr - mq[2*c+1][0].st;
                    return (am > au) ? 2*c + 1 : 2*c;
                end
            end
        end
        return -1;
    endfunction

    task automatic one_cycle(input int pushp, input int readyp, input int only_q);
        int   exp_idx;
        bit   exp_v;
        logic [7:0] exp_full;
        int   q;
        @(negedge clk);
        exp_idx = hold ? lock_idx : pick_idx();
        exp_v   = (exp_idx >= 0);
        for (int i = 0; i < 8; i++) exp_full[i] = (mq[i].size() == 16);
        check("R6", "queue_full", 32'(queue_full), 32'(exp_full));
        check(exp_v ? "R1" : "R7", "grant_valid", 32'(grant_valid), 32'(exp_v));
        if (exp_v && grant_valid) begin
            ent_t e = mq[exp_idx][0];
            check(hold ? "R5" : "R1", "grant_class", 32'(grant_class), 32'(exp_idx / 2));
            if (hold) begin
                check("R5", "grant_mcast", 32'(grant_mcast), 32'(exp_idx % 2));
            end else if (mq[exp_idx ^ 1].size() != 0) begin
                logic [15:0] os = mq[exp_idx ^ 1][0].st;
                if (os == e.st)
                    check("R4", "grant_mcast tie", 32'(grant_mcast), 32'(exp_idx % 2));
                else if ((os > e.st) != ((ctr - e.st) > (ctr - os)))
                    check("R3", "grant_mcast wrap", 32'(grant_mcast), 32'(exp_idx % 2));
                else
                    check("R2", "grant_mcast age", 32'(grant_mcast), 32'(exp_idx % 2));
            end else begin
                check("R2", "grant_mcast single", 32'(grant_mcast), 32'(exp_idx % 2));
            end
            check("R8", "grant stamp/data", {grant_stamp, grant_data}, e);
        end
        // next inputs
        push_valid = ($urandom % 100) < pushp;
        if (only_q >= 0) begin
            push_class = 2'(only_q / 2);
            push_mcast = 1'(only_q % 2);
        end else begin
            push_class = 2'($urandom % 4);
            push_mcast = 1'($urandom % 2);
        end
        push_stamp  = (($urandom % 6) == 0) ? last_st : ctr;
        push_data   = tag;
        grant_ready = ($urandom % 100) < readyp;
        @(posedge clk);
        // model update with the values seen at this edge
        if (exp_v && grant_ready) void'(mq[exp_idx].pop_front());
        hold     = exp_v && !grant_ready;
        lock_idx = exp_idx;
        q = 2 * int'(push_class) + int'(push_mcast);
        if (push_valid) begin
            if (exp_full[q] == 1'b0) mq[q].push_back({push_stamp, push_data});
            last_st = push_stamp;
            tag++;
        end
        ctr++;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        push_valid = 1'b0; push_class = '0; push_mcast = 1'b0;
        push_stamp = '0; push_data = '0; grant_ready = 1'b0;
        hold = 1'b0; lock_idx = -1;
        ctr = 16'hFF00; last_st = 16'hFF00; tag = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check("R9", "grant_valid", 32'(grant_valid), 32'h0);
        check("R9", "queue_full", 32'(queue_full), 32'h0);
        // R6, R5: fill class 0 unicast past capacity with ready held low
        for (int i = 0; i < 24; i++) one_cycle(100, 0, 0);
        // pushes into the full queue while it drains, then random traffic
        for (int i = 0; i < 10; i++) one_cycle(100, 60, 0);
        for (int i = 0; i < 1500; i++) one_cycle(60, 50, -1);
        for (int i = 0; i < 800; i++) one_cycle(25, 85, -1);
        for (int i = 0; i < 60; i++) one_cycle(0, 100, -1);
        // R7: fully drained
        @(negedge clk);
        check("R7", "grant_valid drained", 32'(grant_valid), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule